// File: doc/BRIEF.md
# Cascaded Clock-Enable Strobe Tree

This block turns one free-running clock into a family of single-cycle enable strobes. Each strobe stands for a slower domain, so logic in every domain runs on the same clock and no clock is ever gated. The tree has four levels:

- The root strobe is high on every cycle.
- A bus strobe divides the root by 1 to 4.
- Three peripheral strobes each divide the bus strobe by 1 to 16.
- Three asynchronous-peripheral copies follow peripheral strobe A. The third copy feeds its own sub-divider of 1 to 8.

A second root strobe trails the first by two cycles.

A small write port programs the divide fields and a disable mask. Every divide field holds N-1, so a value of 0 means divide-by-1. A new divide value is taken up only when that stage's counter wraps, so pulses are never shortened or stretched by a change. A flag reports when peripheral strobe B does not run at an integer multiple of the rate of peripheral strobe A.

Top module: `clk_strobe_tree`

## Requirements
- R1: `en_main` is high on every cycle while mask bit 0 is clear. It is low from the cycle after a write that sets that bit.
- R2: `en_main_lag` equals `en_main` from two cycles earlier. It is low for the first two cycles after reset is released.
- R3: `en_bus` pulses once per (F+1) root strobes, where F is the value written at address 1, bits [1:0].
- R4: Address 2 holds the peripheral divide fields: A in bits [3:0], B in bits [7:4] and C in bits [11:8]. Each peripheral strobe pulses once per (field+1) bus strobes.
- R5: `en_asy0`, `en_asy1` and `en_asy2` pulse together with `en_per_a`.
- R6: `en_asy2_sub` pulses once per (F+1) pulses of `en_asy2`, where F is the value written at address 3, bits [2:0]. F resets to 1, so the reset rate is divide-by-2.
- R7: Address 3, bit 3 disables `en_asy2_sub` only. While mask bit 11 is set, the sub-strobe stays off whatever bit 3 holds.
- R8: Mask bits at address 0 map to domains as follows:
  - bit 0: root
  - bit 1: bus
  - bit 2: peripheral A
  - bit 3: peripheral B
  - bit 8: peripheral C
  - bits 4, 5 and 11: asynchronous copies 0, 1 and 2

  A set bit silences its own domain and every domain below it. It leaves the domains above it and the sibling domains running.
- R9: `ratio_err` is high in the cycle after a write exactly when (A+1) is not a multiple of (B+1).
- R10: After a divide field changes, the interval between consecutive pulses of that stage is always either the old period or the new period. Once the new period has appeared, every later interval has the new length.
- R11: Synchronous reset clears all counters and the mask and sets all divide fields to 0, except the sub-divider field. Every strobe is high in the reset state, `en_main_lag` is low and `ratio_err` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the whole tree |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 2 | Register select: 0 mask, 1 bus field, 2 peripheral fields, 3 sub-divider field and disable |
| cfg_wdata | input | 12 | Write data |
| en_main | output | 1 | Root strobe |
| en_main_lag | output | 1 | Root strobe delayed by two cycles |
| en_bus | output | 1 | Bus-domain strobe |
| en_per_a | output | 1 | Peripheral strobe A |
| en_per_b | output | 1 | Peripheral strobe B |
| en_per_c | output | 1 | Peripheral strobe C |
| en_asy0 | output | 1 | Asynchronous-peripheral copy 0 of strobe A |
| en_asy1 | output | 1 | Asynchronous-peripheral copy 1 of strobe A |
| en_asy2 | output | 1 | Asynchronous-peripheral copy 2 of strobe A |
| en_asy2_sub | output | 1 | Sub-divided strobe from copy 2 |
| ratio_err | output | 1 | Peripheral B/A integer-ratio violation |

## Verification
Pulse counts over windows that span whole periods are compared for four divider sets: the reset values, the smallest periods, the largest periods, and a mixed set. Because the windows span whole periods, a wrong field position or an off-by-one divide shows up as a count error, not as a phase error. Each mask bit is set on its own, which separates a missing propagation to the children from a wrong bit assignment that would stop a parent or a sibling. Divider changes are written at several offsets within a period, and the pulse spacing around each change exposes a value that is applied early, which produces runt or stretched intervals. Ratio pairs with the B period shorter than, equal to, longer than and not dividing the A period tell the integer-multiple test apart from a plain comparison.

// File: rtl/clk_tree_pkg.sv
package clk_tree_pkg;
    localparam int BUS_W   = 2;
    localparam int PER_W   = 4;
    localparam int SUB_W   = 3;
    localparam int MASK_W  = 12;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = MASK_W;
    localparam int LAG_CYC = 2;
    localparam int N_PER   = 3;

    localparam logic [SUB_W-1:0] SUB_RST = SUB_W'(1);

    localparam int M_MAIN = 0;
    localparam int M_BUS  = 1;
    localparam int M_PA   = 2;
    localparam int M_PB   = 3;
    localparam int M_AS0  = 4;
    localparam int M_AS1  = 5;
    localparam int M_PC   = 8;
    localparam int M_AS2  = 11;

    localparam logic [ADDR_W-1:0] A_MASK = 2'd0;
    localparam logic [ADDR_W-1:0] A_BUS  = 2'd1;
    localparam logic [ADDR_W-1:0] A_PER  = 2'd2;
    localparam logic [ADDR_W-1:0] A_SUB  = 2'd3;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [BUS_W-1:0]  bus;
        logic [PER_W-1:0]  pc;
        logic [PER_W-1:0]  pb;
        logic [PER_W-1:0]  pa;
        logic [SUB_W-1:0]  sub;
        logic              subdis;
    } cfg_t;
endpackage

// File: rtl/tree_cfg_regs.sv
module tree_cfg_regs
    import clk_tree_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output cfg_t              cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we_i) begin
            case (addr_i)
                A_MASK: cfg_d.mask = wdata_i[MASK_W-1:0];
                A_BUS:  cfg_d.bus  = wdata_i[BUS_W-1:0];
                A_PER: begin
                    cfg_d.pa = wdata_i[PER_W-1:0];
                    cfg_d.pb = wdata_i[2*PER_W-1:PER_W];
                    cfg_d.pc = wdata_i[3*PER_W-1:2*PER_W];
                end
                default: begin
                    cfg_d.sub    = wdata_i[SUB_W-1:0];
                    cfg_d.subdis = wdata_i[SUB_W];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q        <= '0;
            cfg_q.sub    <= SUB_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/strobe_div.sv
module strobe_div #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_DIV = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         parent_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (parent_i) begin
            if (st_q.cnt == st_q.act) begin
                st_d.cnt = '0;
                st_d.act = div_i;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.act <= RST_DIV;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = parent_i && (st_q.cnt == '0);
endmodule

// File: rtl/ratio_check.sv
module ratio_check #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         err_o
);
    localparam int PW = 2 * W + 1;

    logic [W:0] a_n, b_n;
    logic       fits;

    assign a_n = {1'b0, a_i} + 1'b1;
    assign b_n = {1'b0, b_i} + 1'b1;

    always_comb begin
        fits = 1'b0;
        for (int k = 1; k <= (1 << W); k++) begin
            if (PW'(b_n) * PW'(k) == PW'(a_n)) fits = 1'b1;
        end
    end

    assign err_o = !fits;
endmodule

// File: rtl/clk_strobe_tree.sv
module clk_strobe_tree
    import clk_tree_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              en_main,
    output logic              en_main_lag,
    output logic              en_bus,
    output logic              en_per_a,
    output logic              en_per_b,
    output logic              en_per_c,
    output logic              en_asy0,
    output logic              en_asy1,
    output logic              en_asy2,
    output logic              en_asy2_sub,
    output logic              ratio_err
);
    typedef struct packed {
        logic [LAG_CYC-1:0] sh;
    } lag_t;

    cfg_t             cfg;
    lag_t             lag_d, lag_q;
    logic             bus_raw;
    logic             sub_raw;
    logic [N_PER-1:0] per_raw;
    logic [N_PER-1:0] per_off;
    logic [N_PER-1:0] per_en;
    logic [PER_W-1:0] per_div [N_PER];
    logic [2:0]       as_off;
    logic [2:0]       as_en;

    tree_cfg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .addr_i  (cfg_addr),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg)
    );

    // Root strobe and its delayed twin
    assign en_main = !cfg.mask[M_MAIN];

    always_comb begin
        lag_d    = lag_q;
        lag_d.sh = {lag_q.sh[LAG_CYC-2:0], en_main};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lag_q <= '0;
        else        lag_q <= lag_d;
    end

    assign en_main_lag = lag_q.sh[LAG_CYC-1];

    // Bus stage
    strobe_div #(.W(BUS_W), .RST_DIV('0)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .parent_i (en_main),
        .div_i    (cfg.bus),
        .tick_o   (bus_raw)
    );
    assign en_bus = bus_raw && !cfg.mask[M_BUS];

    // Peripheral stages
    assign per_div[0] = cfg.pa;
    assign per_div[1] = cfg.pb;
    assign per_div[2] = cfg.pc;
    assign per_off    = {cfg.mask[M_PC], cfg.mask[M_PB], cfg.mask[M_PA]};

    for (genvar g = 0; g < N_PER; g++) begin : g_per
        strobe_div #(.W(PER_W), .RST_DIV('0)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .parent_i (en_bus),
            .div_i    (per_div[g]),
            .tick_o   (per_raw[g])
        );
        assign per_en[g] = per_raw[g] && !per_off[g];
    end

    assign en_per_a = per_en[0];
    assign en_per_b = per_en[1];
    assign en_per_c = per_en[2];

    // Asynchronous-peripheral copies of strobe A
    assign as_off  = {cfg.mask[M_AS2], cfg.mask[M_AS1], cfg.mask[M_AS0]};
    assign as_en   = {3{en_per_a}} & ~as_off;
    assign en_asy0 = as_en[0];
    assign en_asy1 = as_en[1];
    assign en_asy2 = as_en[2];

    // Sub-divider under copy 2; parent off forces it off
    strobe_div #(.W(SUB_W), .RST_DIV(SUB_RST)) u_sub (
        .clk      (clk),
        .rst_n    (rst_n),
        .parent_i (en_asy2),
        .div_i    (cfg.sub),
        .tick_o   (sub_raw)
    );
    assign en_asy2_sub = sub_raw && !cfg.subdis;

    ratio_check #(.W(PER_W)) u_ratio (
        .a_i   (cfg.pa),
        .b_i   (cfg.pb),
        .err_o (ratio_err)
    );
endmodule

// File: rtl/clk_tree_checker.sv
module clk_tree_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [1:0]  cfg_addr,
    input logic [11:0] cfg_wdata,
    input logic        en_main,
    input logic        en_main_lag,
    input logic        en_bus,
    input logic        en_per_a,
    input logic        en_per_b,
    input logic        en_per_c,
    input logic        en_asy0,
    input logic        en_asy1,
    input logic        en_asy2,
    input logic        en_asy2_sub,
    input logic        ratio_err
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_MAIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd0 && (cfg_wdata & 12'h001) != 12'd0) |=> !en_main); // R1
    AST_LAG_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (en_main_lag == $past(en_main, 2))); // R2
    AST_BUS_UNDER_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        en_bus |-> en_main); // R8
    AST_PER_UNDER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_per_a || en_per_b || en_per_c) |-> en_bus); // R4
    AST_ASY_UNDER_A: assert property (@(posedge clk) disable iff (!rst_n)
        (en_asy0 || en_asy1 || en_asy2) |-> en_per_a); // R5
    AST_SUB_UNDER_ASY2: assert property (@(posedge clk) disable iff (!rst_n)
        en_asy2_sub |-> en_asy2); // R6
    AST_SUB_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd3 && (cfg_wdata & 12'h008) != 12'd0) |=> !en_asy2_sub); // R7
    AST_RATIO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd2 && cfg_wdata == 12'h012) |=> ratio_err); // R9
endmodule

bind clk_strobe_tree clk_tree_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .en_main     (en_main),
    .en_main_lag (en_main_lag),
    .en_bus      (en_bus),
    .en_per_a    (en_per_a),
    .en_per_b    (en_per_b),
    .en_per_c    (en_per_c),
    .en_asy0     (en_asy0),
    .en_asy1     (en_asy1),
    .en_asy2     (en_asy2),
    .en_asy2_sub (en_asy2_sub),
    .ratio_err   (ratio_err)
);

// File: tb/tb_clk_strobe_tree.sv
module tb_clk_strobe_tree;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [11:0] cfg_wdata = 12'd0;
    logic en_main, en_main_lag, en_bus, en_per_a, en_per_b, en_per_c;
    logic en_asy0, en_asy1, en_asy2, en_asy2_sub, ratio_err;
    logic [9:0] outs;

    int n_chk = 0;
    int n_bad = 0;

    // bench-side model of the programmed configuration (divide values, not fields)
    int d_bus = 1, d_a = 1, d_b = 1, d_c = 1, d_sub = 2;
    logic [11:0] m = 12'd0;
    bit sd = 1'b0;

    clk_strobe_tree dut (.*);

    assign outs = {en_asy2_sub, en_asy2, en_asy1, en_asy0, en_per_c,
                   en_per_b, en_per_a, en_bus, en_main_lag, en_main};

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic program_all();
        wr(2'd1, 12'(d_bus - 1));
        wr(2'd2, {4'(d_c - 1), 4'(d_b - 1), 4'(d_a - 1)});
        wr(2'd3, {8'd0, sd, 3'(d_sub - 1)});
        wr(2'd0, m);
    endtask

    function automatic int gcd(input int x, input int y);
        int a = x, b = y, t;
        while (b != 0) begin t = a % b; a = b; b = t; end
        return a;
    endfunction

    function automatic int lcm(input int x, input int y);
        return (x / gcd(x, y)) * y;
    endfunction

    // Count pulses over whole periods and compare with the bench model.
    task automatic measure(input int settle, input string over);
        int per[10];
        bit on[10];
        int cnt[10];
        int len;
        string tags[10];
        tags = '{"R1", "R2", "R3", "R4", "R4", "R4", "R5", "R5", "R5", "R6"};
        per = '{1, 1, d_bus, d_bus*d_a, d_bus*d_b, d_bus*d_c,
                d_bus*d_a, d_bus*d_a, d_bus*d_a, d_bus*d_a*d_sub};
        on[0] = !m[0];
        on[1] = on[0];
        on[2] = on[0] && !m[1];
        on[3] = on[2] && !m[2];
        on[4] = on[2] && !m[3];
        on[5] = on[2] && !m[8];
        on[6] = on[3] && !m[4];
        on[7] = on[3] && !m[5];
        on[8] = on[3] && !m[11];
        on[9] = on[8] && !sd;
        len = 1;
        for (int i = 0; i < 10; i++) len = lcm(len, per[i]);
        len = 2 * len;
        if (len < 64) len = 64;
        repeat (settle) @(negedge clk);
        for (int i = 0; i < 10; i++) cnt[i] = 0;
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            for (int i = 0; i < 10; i++) cnt[i] += int'(outs[i]);
        end
        for (int i = 0; i < 10; i++) begin
            int exp;
            exp = on[i] ? len / per[i] : 0;
            chk(cnt[i] == exp, (over == "") ? tags[i] : over, cnt[i], exp);
        end
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // reset state, sampled before the first edge with reset released (R11)
        chk(outs == 10'b1111111101, "R11", int'(outs), 10'b1111111101);
        chk(ratio_err == 1'b0, "R11", int'(ratio_err), 0);
        @(negedge clk);
        chk(en_main_lag == 1'b0 && en_asy2_sub == 1'b0, "R2", int'({en_main_lag, en_asy2_sub}), 0);
        @(negedge clk);
        chk(en_main_lag == 1'b1 && en_asy2_sub == 1'b1, "R6", int'({en_main_lag, en_asy2_sub}), 3);
    endtask

    task automatic t_dividers();
        measure(8, "");
        d_bus = 3; d_a = 4; d_b = 2; d_c = 5; d_sub = 3;
        program_all(); measure(1200, "");
        d_bus = 4; d_a = 16; d_b = 8; d_c = 1; d_sub = 8;
        program_all(); measure(1200, "");
        d_bus = 2; d_a = 6; d_b = 3; d_c = 16; d_sub = 1;
        program_all(); measure(1200, "");
    endtask

    task automatic t_masks();
        int bits[8];
        bits = '{0, 1, 2, 3, 8, 4, 5, 11};
        d_bus = 3; d_a = 4; d_b = 2; d_c = 5; d_sub = 3; m = 12'd0; sd = 1'b0;
        program_all(); measure(1200, "R8");
        foreach (bits[i]) begin
            m = 12'd1 << bits[i];
            wr(2'd0, m);
            measure(8, "R8");
        end
        m = 12'd0; sd = 1'b1;
        program_all(); measure(8, "R7");
        m = 12'h800; sd = 1'b0;
        program_all(); measure(8, "R7");
        m = 12'h800; sd = 1'b1;
        program_all(); measure(8, "R7");
        m = 12'd0; sd = 1'b0;
        program_all();
    endtask

    task automatic t_lag();
        logic h1 = 1'b0, h2 = 1'b0;
        int bad = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i >= 2 && en_main_lag != h2) bad++;
            h2 = h1; h1 = en_main;
            cfg_we = (i == 10 || i == 31 || i == 40 || i == 42);
            cfg_addr = 2'd0;
            cfg_wdata = (i == 10 || i == 40) ? 12'h001 : 12'h000;
        end
        cfg_we = 1'b0;
        chk(bad == 0, "R2", bad, 0);
        chk(en_main == 1'b1, "R1", int'(en_main), 1);
    endtask

    task automatic t_ratio();
        int pairs[6][2];
        pairs = '{'{4, 2}, '{3, 2}, '{16, 8}, '{16, 16}, '{1, 2}, '{15, 5}};
        foreach (pairs[i]) begin
            int e;
            wr(2'd2, {4'd0, 4'(pairs[i][1] - 1), 4'(pairs[i][0] - 1)});
            e = (pairs[i][0] % pairs[i][1] != 0) ? 1 : 0;
            chk(int'(ratio_err) == e, "R9", int'(ratio_err), e);
        end
        wr(2'd2, 12'd0);
    endtask

    task automatic t_switch();
        int seq[4];
        seq = '{4, 2, 3, 1};
        d_bus = 4; d_a = 1; d_b = 1; d_c = 1; d_sub = 1; m = 12'd0; sd = 1'b0;
        program_all();
        repeat (20) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            int last = -1, bad = 0, lastiv = 0;
            bit seen_new = 1'b0;
            repeat (k + 1) @(negedge clk);
            wr(2'd1, 12'(seq[k+1] - 1));
            for (int t = 0; t < 40; t++) begin
                if (en_bus) begin
                    if (last >= 0) begin
                        lastiv = t - last;
                        if (lastiv == seq[k+1]) seen_new = 1'b1;
                        else if (lastiv != seq[k] || seen_new) bad++;
                    end
                    last = t;
                end
                @(negedge clk);
            end
            chk(bad == 0, "R10", bad, 0);
            chk(lastiv == seq[k+1], "R10", lastiv, seq[k+1]);
        end
        d_bus = seq[3];
    endtask

    initial begin
        #(20 * 190000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_dividers();
        t_masks();
        t_lag();
        t_ratio();
        t_switch();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule